// File: doc/BRIEF.md
# Decomposed Seven-Input Majority Gate

This block raises its output when four or more of its seven input bits are set. It does not use one flat sum-of-products. The logic comes in two stages. The first stage reduces the four low inputs to a few symmetric terms, and each term is formed from XORs of products. These terms are the parity of the four bits, the XOR of all their pairwise ANDs, and the AND of all four. Read together, the three terms give the binary population count of the low group. After this stage the four low bits play no further part. The second stage takes that count and the three high inputs and decides the threshold.

The low-group count is also a useful result by itself, so it comes out on its own port. An optional output register can be placed on both results, and it adds one cycle of latency. The second stage can be built in one of two ways. One form adds the count and then compares. The other is a reduced form that chooses the result from the count bits. Both forms give the same answer.

Top module: `majority7Decomp`

## Requirements
- R1: `majOut` is 1 exactly when at least four of the seven bits of `dataIn` are 1, and 0 otherwise.
- R2: `countOut` is the number of ones in `dataIn[3:0]`, as an unsigned binary value from 0 to 4.
- R3: `countOut[0]` is the XOR of the four bits `dataIn[3:0]`.
- R4: `countOut[1]` is the XOR of the six pairwise ANDs of `dataIn[3:0]`. Inside the block, the XOR of the four triple ANDs equals `countOut[0] & countOut[1]`.
- R5: `countOut[2]` is the AND of all four bits `dataIn[3:0]`.
- R6: With `OUT_REG = 1` (the default), both outputs show the result for the `dataIn` value sampled at a rising edge of `clk`, and they change only after that edge.
- R7: While `rstN` is low, the registered outputs are held at 0. The `countOut` value is 0 and `majOut` is 0, whatever `dataIn` is.
- R8: `dataIn[6:4]` has no effect on `countOut`.
- R9: At the threshold boundary, exactly three set bits give `majOut` = 0 and exactly four give `majOut` = 1, whichever inputs hold those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 7 | The seven voted bits; bits 3..0 form the counted group |
| countOut | output | 3 | Population count of `dataIn[3:0]` (bit 2 weight 4, bit 1 weight 2, bit 0 weight 1) |
| majOut | output | 1 | Majority decision, 1 when four or more inputs are set |

## Verification
The count of the low group and the majority decision come out of the same register on the same clock edge. A fault in the first stage can therefore appear in both outputs in the same cycle, or in only one of them. The bench sends a new input word every cycle and queues the expected count and majority for each word. It then checks both fields against that one queued item in the cycle after the edge. This covers all 128 input words, a sweep that holds the low nibble fixed while the high bits change, and the boundary where three set bits change to four. In every case a wrong field is named by its own requirement.

// File: rtl/majPkg.sv
package majPkg;
  localparam int LOW_W  = 4;
  localparam int HIGH_W = 3;
  localparam int ALL_W  = LOW_W + HIGH_W;
  localparam int CNT_W  = $clog2(LOW_W + 1);
  localparam int THRESH = (ALL_W + 1) / 2;

  typedef struct packed {
    logic weight4;
    logic weight2;
    logic weight1;
  } lowCount_t;
endpackage

// File: rtl/majCounter4.sv
module majCounter4
  import majPkg::*;
(
  input  logic [LOW_W-1:0] lowBits,
  output lowCount_t        lowCount
);
  logic parityTerm;
  logic pairTerm;
  logic tripleTerm;
  logic allTerm;

  always_comb begin
    pairTerm   = 1'b0;
    tripleTerm = 1'b0;
    for (int i = 0; i < LOW_W; i++) begin
      for (int j = i + 1; j < LOW_W; j++) begin
        pairTerm = pairTerm ^ (lowBits[i] & lowBits[j]);
        for (int k = j + 1; k < LOW_W; k++) begin
          tripleTerm = tripleTerm ^ (lowBits[i] & lowBits[j] & lowBits[k]);
        end
      end
    end
  end

  assign parityTerm = ^lowBits;
  assign allTerm    = &lowBits;

  assign lowCount.weight4 = allTerm;
  assign lowCount.weight2 = pairTerm;
  assign lowCount.weight1 = parityTerm;

  always_comb begin
    a_r4_triple_product: assert (tripleTerm == (parityTerm & pairTerm));
    a_r2_count_value: assert ({allTerm, pairTerm, parityTerm} == CNT_W'($countones(lowBits)));
  end
endmodule

// File: rtl/majThreshold.sv
module majThreshold
  import majPkg::*;
#(
  parameter bit USE_ADDER = 1'b0
) (
  input  lowCount_t         lowCount,
  input  logic [HIGH_W-1:0] highBits,
  output logic              majority
);
  generate
    if (USE_ADDER) begin : g_adder
      localparam int SUM_W = $clog2(ALL_W + 1);
      logic [SUM_W-1:0] highPop;
      logic [SUM_W-1:0] total;
      always_comb begin
        highPop = '0;
        for (int b = 0; b < HIGH_W; b++) begin
          highPop = highPop + SUM_W'(highBits[b]);
        end
        total    = SUM_W'(lowCount) + highPop;
        majority = (total >= SUM_W'(THRESH));
      end
    end else begin : g_reduced
      logic anyHigh;
      logic twoHigh;
      logic allHigh;
      assign anyHigh = |highBits;
      assign twoHigh = (highBits[0] & highBits[1]) | (highBits[0] & highBits[2])
                     | (highBits[1] & highBits[2]);
      assign allHigh = &highBits;
      assign majority = lowCount.weight4
                      | (lowCount.weight2 &  lowCount.weight1 & anyHigh)
                      | (lowCount.weight2 & ~lowCount.weight1 & twoHigh)
                      | (~lowCount.weight2 & lowCount.weight1 & allHigh);
    end
  endgenerate

  always_comb begin
    a_r1_threshold: assert (majority ==
      ((int'(lowCount) + $countones(highBits)) >= THRESH));
  end
endmodule

// File: rtl/majOutStage.sv
module majOutStage
  import majPkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  lowCount_t  countIn,
  input  logic       majIn,
  output lowCount_t  countQ,
  output logic       majQ
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          countQ <= '0;
          majQ   <= 1'b0;
        end else begin
          countQ <= countIn;
          majQ   <= majIn;
        end
      end

      a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (majQ == $past(majIn)) && (countQ == $past(countIn)));

      always_comb begin
        if (!rstN) begin
          a_r7_reset_clear: assert (countQ == '0 && majQ == 1'b0);
        end
      end
    end else begin : g_comb
      assign countQ = countIn;
      assign majQ   = majIn;
    end
  endgenerate
endmodule

// File: rtl/majority7Decomp.sv
module majority7Decomp
  import majPkg::*;
#(
  parameter bit OUT_REG   = 1'b1,
  parameter bit USE_ADDER = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ALL_W-1:0] dataIn,
  output logic [CNT_W-1:0] countOut,
  output logic             majOut
);
  lowCount_t lowCount;
  lowCount_t countQ;
  logic      majNext;

  majCounter4 u_counter (
    .lowBits  (dataIn[LOW_W-1:0]),
    .lowCount (lowCount)
  );

  majThreshold #(.USE_ADDER(USE_ADDER)) u_threshold (
    .lowCount (lowCount),
    .highBits (dataIn[ALL_W-1:LOW_W]),
    .majority (majNext)
  );

  majOutStage #(.OUT_REG(OUT_REG)) u_outStage (
    .clk     (clk),
    .rstN    (rstN),
    .countIn (lowCount),
    .majIn   (majNext),
    .countQ  (countQ),
    .majQ    (majOut)
  );

  assign countOut = countQ;
endmodule

// File: tb/majority7Decomp_tb.sv
module majority7Decomp_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  typedef struct {
    logic [2:0] cnt;
    logic       maj;
    int         ones;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] dataIn = '0;
  logic [2:0] countOut;
  logic       majOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;
  expItem_t scoreQ[$];

  majority7Decomp u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .countOut(countOut), .majOut(majOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int popLow(input logic [6:0] v);
    int n = 0;
    for (int b = 0; b < 4; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic int popAll(input logic [6:0] v);
    int n = 0;
    for (int b = 0; b < 7; b++) n += int'(v[b]);
    return n;
  endfunction

  task automatic drive(input logic [6:0] v, input string tag);
    expItem_t it;
    @(negedge clk);
    dataIn  = v;
    it.cnt  = 3'(popLow(v));
    it.maj  = (popAll(v) >= 4);
    it.ones = popAll(v);
    it.tag  = tag;
    scoreQ.push_back(it);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: one queued item per cycle, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      check(majOut == e.maj, (e.ones == 3 || e.ones == 4) ? "R9 majority boundary" : "R1 majority",
            int'(majOut), int'(e.maj));
      check(countOut == e.cnt, (e.tag == "R8") ? "R8 high bits ignored" : "R2 count",
            int'(countOut), int'(e.cnt));
      check(countOut[0] == e.cnt[0], "R3 parity bit", int'(countOut[0]), int'(e.cnt[0]));
      check(countOut[1] == e.cnt[1], "R4 pair bit", int'(countOut[1]), int'(e.cnt[1]));
      check(countOut[2] == e.cnt[2], "R5 all-ones bit", int'(countOut[2]), int'(e.cnt[2]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    // R7: reset holds outputs low even with all inputs set
    dataIn = 7'h7F;
    repeat (3) @(negedge clk);
    check(countOut == 3'd0, "R7 reset count", int'(countOut), 0);
    check(majOut == 1'b0, "R7 reset majority", int'(majOut), 0);
    dataIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6: new input does not reach the outputs before the next edge
    drive(7'h7F, "R6");
    #1;
    check(majOut == 1'b0, "R6 majority before edge", int'(majOut), 0);
    check(countOut == 3'd0, "R6 count before edge", int'(countOut), 0);

    // exhaustive sweep, ascending then descending
    for (int v = 0; v < 128; v++) drive(7'(v), "R1");
    for (int v = 127; v >= 0; v--) drive(7'(v), "R1");

    // R8: fixed low nibble, all high patterns
    for (int h = 0; h < 8; h++) drive({3'(h), 4'b1011}, "R8");
    for (int h = 0; h < 8; h++) drive({3'(h), 4'b0100}, "R8");

    // R9: three vs four set bits spread over both groups
    drive(7'b0000111, "R9");
    drive(7'b0001111, "R9");
    drive(7'b1110000, "R9");
    drive(7'b1110001, "R9");
    drive(7'b1010100, "R9");
    drive(7'b1011100, "R9");

    repeat (3) @(negedge clk);
    check(scoreQ.size() == 0, "R6 queue drained", scoreQ.size(), 0);
    finishRun();
  end
endmodule